// File: doc/BRIEF.md
# CAN Bit Timing Unit

This block produces the bit timing for a CAN node. A programmable prescaler divides the system clock into time quanta. Each nominal bit is one fixed synchronisation quantum, then a first phase segment and then a second phase segment, both with programmable lengths. The sample point sits at the end of the first phase segment and the transmit point at the end of the second.

The block watches the received line for recessive-to-dominant transitions. When the bus is reported idle, such a transition forces a hard synchronisation, and the bit restarts at the end of its synchronisation quantum. At other times the transition measures a phase error. A late edge lengthens the first segment and an early edge shortens the second. The correction is capped by a programmable jump width, and at most one correction is applied per bit.

The outputs are a one-cycle sample strobe carrying the sampled line value and a one-cycle transmit-point strobe. The configuration fields are captured only while init mode is asserted. A configuration whose bit would be shorter than five quanta raises an error flag.

Top module: `can_bit_timer`

## Requirements
- R1: One quantum lasts (brp_in+1) clock cycles. With no edges on the line, a bit lasts 1 + (seg1_in+1) + (seg2_in+1) quanta, in the order: sync quantum, first segment, second segment.
- R2: sample_stb is high for one cycle at the end of the first segment and carries the received line value on sample_bit. tx_stb is high for one cycle at the end of the second segment, (seg2_in+1) quanta after sample_stb when there is no correction.
- R3: The configuration inputs are captured only while init_mode is 1. Changes at other times have no effect on timing or on cfg_err.
- R4: cfg_err is 1 exactly when 3 + seg1_in + seg2_in < 5, using the captured values.
- R5: While init_mode is 1, neither strobe fires. After init_mode falls, the first sample_stb appears (seg1_in+2) quanta later.
- R6: A falling edge of rx_in seen while bus_idle=1 and init_mode=0 is a hard sync. The bit restarts at the start of the first segment. If rx_in is first low at clock edge E, sample_stb is high in the cycle after clock edge E + 1 + (seg1_in+1)·Q, where Q = brp_in+1.
- R7: A falling edge inside quantum j (counted from 0) of the first segment lengthens that segment by min(j+1, sjw_in+1) quanta.
- R8: A falling edge inside quantum j of the second segment, which is L2 = seg2_in+1 quanta long, shortens it by min(L2-j, sjw_in+1) quanta. The segment still ends no earlier than the end of quantum j.
- R9: Only the first falling edge in a bit is used for correction. Further edges in the same bit are ignored, and the segment lengths return to nominal in the next bit.
- R10: Rising edges of rx_in cause no correction and no hard sync.
- R11: sample_stb and tx_stb are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in | input | 1 | Received bus line (1 = recessive) |
| init_mode | input | 1 | Init mode: configuration capture; timing held idle |
| bus_idle | input | 1 | Bus-idle hint; enables hard sync |
| brp_in | input | BRP_W (6) | Prescaler field; quantum = brp_in+1 clocks |
| seg1_in | input | SEG1_W (4) | First phase segment length minus one |
| seg2_in | input | SEG2_W (3) | Second phase segment length minus one |
| sjw_in | input | SJW_W (2) | Jump width minus one |
| sample_stb | output | 1 | One-cycle strobe at the sample point |
| sample_bit | output | 1 | Line value captured at the sample point |
| tx_stb | output | 1 | One-cycle strobe at the transmit point |
| cfg_err | output | 1 | Captured configuration gives a bit under five quanta |

## Verification
The assertions assume that the configuration fields settle before init_mode falls, and that a correction is never asked to move a segment end that has already passed. The cap and single-correction properties rest on that second assumption. The stimulus drives rx_in only at falling clock edges and uses a four-cycle quantum. Every line edge is placed one cycle into a quantum the bench has computed in advance, so each edge is seen and acted on inside the intended quantum. Between scenarios the line is returned to recessive during the sync quantum or the second segment, where a rising transition must leave the timing untouched.

// File: rtl/cbt_pkg.sv
`timescale 1ns/1ps
package cbt_pkg;
   // Segment the bit sequencer is currently in
   typedef enum logic [1:0] {
      SEG_SYNC = 2'd0,
      SEG_ONE  = 2'd1,
      SEG_TWO  = 2'd2
   } seg_e;

   // Shortest legal nominal bit, in quanta
   localparam int MIN_BIT_TQ = 5;

   function automatic int imax3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction
endpackage

// File: rtl/cbt_cfg_regs.sv
`timescale 1ns/1ps
module cbt_cfg_regs
   import cbt_pkg::*;
#(
   parameter int BRP_W    = 6,
   parameter int SEG1_W   = 4,
   parameter int SEG2_W   = 3,
   parameter int SJW_W    = 2,
   parameter int RST_BRP  = 0,
   parameter int RST_SEG1 = 3,
   parameter int RST_SEG2 = 2,
   parameter int RST_SJW  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init_mode,
   input  logic [BRP_W-1:0]  brp_in,
   input  logic [SEG1_W-1:0] seg1_in,
   input  logic [SEG2_W-1:0] seg2_in,
   input  logic [SJW_W-1:0]  sjw_in,
   output logic [BRP_W-1:0]  brp_q,
   output logic [SEG1_W-1:0] seg1_q,
   output logic [SEG2_W-1:0] seg2_q,
   output logic [SJW_W-1:0]  sjw_q,
   output logic              cfg_err
);
   localparam int TW = ((SEG1_W > SEG2_W) ? SEG1_W : SEG2_W) + 2;
   typedef logic [TW-1:0] tot_t;

   // elaboration-time sanity checks of the reset configuration
   generate
      if (RST_SEG1 + RST_SEG2 + 3 < MIN_BIT_TQ) begin : g_bad_rst
         $error("reset configuration gives a bit shorter than the minimum");
      end
      if (RST_BRP >= (1 << BRP_W)) begin : g_bad_brp
         $error("reset prescaler value does not fit BRP_W");
      end
   endgenerate

   tot_t bit_tq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         brp_q  <= BRP_W'(RST_BRP);
         seg1_q <= SEG1_W'(RST_SEG1);
         seg2_q <= SEG2_W'(RST_SEG2);
         sjw_q  <= SJW_W'(RST_SJW);
      end else if (init_mode) begin
         brp_q  <= brp_in;
         seg1_q <= seg1_in;
         seg2_q <= seg2_in;
         sjw_q  <= sjw_in;
      end
   end

   assign bit_tq  = tot_t'(seg1_q) + tot_t'(seg2_q) + tot_t'(3);
   assign cfg_err = (bit_tq < tot_t'(MIN_BIT_TQ));

   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !init_mode |=> ($stable(brp_q) && $stable(seg1_q) && $stable(seg2_q) && $stable(sjw_q))); // R3
endmodule

// File: rtl/cbt_quantum_div.sv
`timescale 1ns/1ps
module cbt_quantum_div #(
   parameter int BRP_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [BRP_W-1:0] brp,
   output logic             tq_tick
);
   generate
      if (BRP_W < 1) begin : g_bad_w
         $error("BRP_W must be at least 1");
      end
   endgenerate

   logic [BRP_W-1:0] qcnt_q;

   assign tq_tick = run && (qcnt_q == brp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         qcnt_q <= '0;
      end else if (!run || restart) begin
         qcnt_q <= '0;
      end else if (tq_tick) begin
         qcnt_q <= '0;
      end else begin
         qcnt_q <= qcnt_q + BRP_W'(1);
      end
   end

   AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (tq_tick && brp != '0) |=> !tq_tick); // R1
   AST_QCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (qcnt_q <= brp)); // R1
endmodule

// File: rtl/cbt_rx_edge.sv
`timescale 1ns/1ps
module cbt_rx_edge #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_in,
   output logic rx_bit,
   output logic fall
);
   logic rx_s;
   logic rx_d_q;
   logic rx_d2_q;

   generate
      if (SYNC_STAGES < 0) begin : g_bad_stages
         $error("SYNC_STAGES must not be negative");
      end
      if (SYNC_STAGES == 0) begin : g_direct
         assign rx_s = rx_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= '1;
            end else begin
               chain_q[0] <= rx_in;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  chain_q[i] <= chain_q[i-1];
               end
            end
         end
         assign rx_s = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_d_q  <= 1'b1;
         rx_d2_q <= 1'b1;
      end else begin
         rx_d_q  <= rx_s;
         rx_d2_q <= rx_d_q;
      end
   end

   assign rx_bit = rx_d_q;
   assign fall   = rx_d2_q & ~rx_d_q;

   AST_FALL_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall); // R10
endmodule

// File: rtl/cbt_seg_fsm.sv
`timescale 1ns/1ps
module cbt_seg_fsm
   import cbt_pkg::*;
#(
   parameter int SEG1_W = 4,
   parameter int SEG2_W = 3,
   parameter int SJW_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              tick,
   input  logic              fall,
   input  logic              bus_idle,
   input  logic              rx_bit,
   input  logic [SEG1_W-1:0] seg1,
   input  logic [SEG2_W-1:0] seg2,
   input  logic [SJW_W-1:0]  sjw,
   output logic              hard_sync,
   output logic              sample_stb,
   output logic              sample_bit,
   output logic              tx_stb
);
   localparam int LW = imax3(SEG1_W, SEG2_W, SJW_W) + 2;
   typedef logic [LW-1:0] tq_t;

   seg_e  st_q;
   tq_t   cnt_q;
   tq_t   ext_q;
   tq_t   shr_q;
   logic  done_q;

   tq_t   len1, len2, jump;
   tq_t   late_err, early_err;
   tq_t   ext_now, shr_now;
   logic  resync;
   logic  end1, end2;

   assign len1 = tq_t'(seg1) + tq_t'(1);
   assign len2 = tq_t'(seg2) + tq_t'(1);
   assign jump = tq_t'(sjw) + tq_t'(1);

   assign hard_sync = run & fall & bus_idle;
   assign resync    = run & fall & ~bus_idle & ~done_q;

   // phase error in quanta, measured from the end of the sync quantum
   assign late_err  = cnt_q + tq_t'(1);
   assign early_err = len2 - cnt_q;

   always_comb begin
      ext_now = ext_q;
      shr_now = shr_q;
      if (resync && st_q == SEG_ONE) begin
         ext_now = (late_err < jump) ? late_err : jump;
      end
      if (resync && st_q == SEG_TWO) begin
         shr_now = (early_err < jump) ? early_err : jump;
      end
   end

   assign end1 = (cnt_q + tq_t'(1)) >= (len1 + ext_now);
   assign end2 = (cnt_q + tq_t'(1)) >= (len2 - shr_now);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= SEG_SYNC;
         cnt_q      <= '0;
         ext_q      <= '0;
         shr_q      <= '0;
         done_q     <= 1'b0;
         sample_stb <= 1'b0;
         sample_bit <= 1'b1;
         tx_stb     <= 1'b0;
      end else if (!run) begin
         st_q       <= SEG_SYNC;
         cnt_q      <= '0;
         ext_q      <= '0;
         shr_q      <= '0;
         done_q     <= 1'b0;
         sample_stb <= 1'b0;
         tx_stb     <= 1'b0;
      end else begin
         sample_stb <= 1'b0;
         tx_stb     <= 1'b0;
         if (hard_sync) begin
            st_q   <= SEG_ONE;
            cnt_q  <= '0;
            ext_q  <= '0;
            shr_q  <= '0;
            done_q <= 1'b1;
         end else begin
            if (resync) begin
               done_q <= 1'b1;
               ext_q  <= ext_now;
               shr_q  <= shr_now;
            end
            if (tick) begin
               unique case (st_q)
                  SEG_SYNC: begin
                     st_q  <= SEG_ONE;
                     cnt_q <= '0;
                  end
                  SEG_ONE: begin
                     if (end1) begin
                        st_q       <= SEG_TWO;
                        cnt_q      <= '0;
                        sample_stb <= 1'b1;
                        sample_bit <= rx_bit;
                     end else begin
                        cnt_q <= cnt_q + tq_t'(1);
                     end
                  end
                  SEG_TWO: begin
                     if (end2) begin
                        st_q   <= SEG_SYNC;
                        cnt_q  <= '0;
                        tx_stb <= 1'b1;
                        done_q <= 1'b0;
                        ext_q  <= '0;
                        shr_q  <= '0;
                     end else begin
                        cnt_q <= cnt_q + tq_t'(1);
                     end
                  end
                  default: begin
                     st_q  <= SEG_SYNC;
                     cnt_q <= '0;
                  end
               endcase
            end
         end
      end
   end

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(sample_stb && tx_stb)); // R11
   AST_SAMPLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |=> !sample_stb); // R2
   AST_TX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_stb |=> !tx_stb); // R2
   AST_QUIET_INIT: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(run) == 1'b0) |-> (!sample_stb && !tx_stb)); // R5
   AST_HARD_SYNC_START: assert property (@(posedge clk) disable iff (!rst_n)
      hard_sync |=> (st_q == SEG_ONE && cnt_q == '0 && ext_q == '0)); // R6
   AST_EXT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      ext_q <= jump); // R7
   AST_SHRINK_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      (shr_q <= jump) && (shr_q <= len2)); // R8
   AST_ONE_RESYNC: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && run && st_q == SEG_ONE && !hard_sync) |=>
         (ext_q == $past(ext_q) || st_q == SEG_SYNC || !run)); // R9
endmodule

// File: rtl/can_bit_timer.sv
`timescale 1ns/1ps
module can_bit_timer
   import cbt_pkg::*;
#(
   parameter int BRP_W       = 6,
   parameter int SEG1_W      = 4,
   parameter int SEG2_W      = 3,
   parameter int SJW_W       = 2,
   parameter int SYNC_STAGES = 0,
   parameter int RST_BRP     = 0,
   parameter int RST_SEG1    = 3,
   parameter int RST_SEG2    = 2,
   parameter int RST_SJW     = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_in,
   input  logic              init_mode,
   input  logic              bus_idle,
   input  logic [BRP_W-1:0]  brp_in,
   input  logic [SEG1_W-1:0] seg1_in,
   input  logic [SEG2_W-1:0] seg2_in,
   input  logic [SJW_W-1:0]  sjw_in,
   output logic              sample_stb,
   output logic              sample_bit,
   output logic              tx_stb,
   output logic              cfg_err
);
   generate
      if (SEG1_W < 1 || SEG2_W < 1 || SJW_W < 1) begin : g_bad_fields
         $error("segment and jump fields need at least one bit");
      end
   endgenerate

   logic [BRP_W-1:0]  brp_q;
   logic [SEG1_W-1:0] seg1_q;
   logic [SEG2_W-1:0] seg2_q;
   logic [SJW_W-1:0]  sjw_q;
   logic              run;
   logic              tq_tick;
   logic              rx_bit;
   logic              fall;
   logic              hard_sync;

   assign run = ~init_mode;

   cbt_cfg_regs #(
      .BRP_W(BRP_W), .SEG1_W(SEG1_W), .SEG2_W(SEG2_W), .SJW_W(SJW_W),
      .RST_BRP(RST_BRP), .RST_SEG1(RST_SEG1), .RST_SEG2(RST_SEG2), .RST_SJW(RST_SJW)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .init_mode(init_mode),
      .brp_in(brp_in), .seg1_in(seg1_in), .seg2_in(seg2_in), .sjw_in(sjw_in),
      .brp_q(brp_q), .seg1_q(seg1_q), .seg2_q(seg2_q), .sjw_q(sjw_q),
      .cfg_err(cfg_err)
   );

   cbt_quantum_div #(.BRP_W(BRP_W)) u_div (
      .clk(clk), .rst_n(rst_n), .run(run), .restart(hard_sync),
      .brp(brp_q), .tq_tick(tq_tick)
   );

   cbt_rx_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .rx_bit(rx_bit), .fall(fall)
   );

   cbt_seg_fsm #(.SEG1_W(SEG1_W), .SEG2_W(SEG2_W), .SJW_W(SJW_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tq_tick), .fall(fall),
      .bus_idle(bus_idle), .rx_bit(rx_bit),
      .seg1(seg1_q), .seg2(seg2_q), .sjw(sjw_q),
      .hard_sync(hard_sync), .sample_stb(sample_stb),
      .sample_bit(sample_bit), .tx_stb(tx_stb)
   );
endmodule

// File: tb/can_bit_timer_tb.sv
`timescale 1ns/1ps
module can_bit_timer_tb;
   // bench configuration: quantum Q=4 clocks, seg1 6 tq, seg2 3 tq, jump 3 tq
   localparam int Q    = 4;
   localparam int L1   = 6;
   localparam int L2   = 3;
   localparam int NBT  = 1 + L1 + L2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_in = 1'b1;
   logic       init_mode = 1'b1;
   logic       bus_idle = 1'b0;
   logic [5:0] brp_in = 6'd3;
   logic [3:0] seg1_in = 4'd5;
   logic [2:0] seg2_in = 3'd2;
   logic [1:0] sjw_in = 2'd2;
   logic       sample_stb, sample_bit, tx_stb, cfg_err;

   int cyc = 0;
   int errors = 0;
   int checks = 0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   can_bit_timer u_dut (
      .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .init_mode(init_mode),
      .bus_idle(bus_idle), .brp_in(brp_in), .seg1_in(seg1_in),
      .seg2_in(seg2_in), .sjw_in(sjw_in), .sample_stb(sample_stb),
      .sample_bit(sample_bit), .tx_stb(tx_stb), .cfg_err(cfg_err)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_tx(output int t);
      do @(negedge clk); while (!tx_stb);
      t = cyc;
   endtask

   task automatic wait_sample(output int s);
      do @(negedge clk); while (!sample_stb);
      s = cyc;
   endtask

   task automatic goto_cyc(input int target);
      while (cyc < target) @(negedge clk);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk("R2 reset sample_stb", int'(sample_stb), 0);
      chk("R2 reset tx_stb", int'(tx_stb), 0);
      chk("R4 reset cfg_err", int'(cfg_err), 0);
      rst_n = 1'b1;
   endtask

   task automatic t_cfg_err();
      seg1_in = 4'd0; seg2_in = 3'd0;
      repeat (2) @(negedge clk);
      chk("R4 bit of 3 tq", int'(cfg_err), 1);
      seg1_in = 4'd1; seg2_in = 3'd0;
      repeat (2) @(negedge clk);
      chk("R4 bit of 4 tq", int'(cfg_err), 1);
      seg1_in = 4'd1; seg2_in = 3'd1;
      repeat (2) @(negedge clk);
      chk("R4 bit of 5 tq", int'(cfg_err), 0);
      seg1_in = 4'd5; seg2_in = 3'd2;
      repeat (2) @(negedge clk);
      chk("R4 working config", int'(cfg_err), 0);
   endtask

   task automatic t_init_release();
      int n = 0;
      int r;
      int s;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (sample_stb || tx_stb) n++;
      end
      chk("R5 no strobes in init", n, 0);
      init_mode = 1'b0;
      r = cyc;
      wait_sample(s);
      chk("R5 first sample after release", s - r, (1 + L1) * Q);
   endtask

   task automatic t_period();
      int t1, s, t2;
      wait_tx(t1);
      wait_sample(s);
      chk("R2 sample_bit recessive", int'(sample_bit), 1);
      wait_tx(t2);
      chk("R1 sync plus seg1", s - t1, (1 + L1) * Q);
      chk("R2 sample to tx", t2 - s, L2 * Q);
      chk("R1 bit period", t2 - t1, NBT * Q);
   endtask

   task automatic t_ignore_writes();
      int t1, t2;
      wait_tx(t1);
      brp_in = 6'd0; seg1_in = 4'd0; seg2_in = 3'd0; sjw_in = 2'd3;
      wait_tx(t2);
      wait_tx(t2);
      chk("R3 period unchanged", t2 - t1, 2 * NBT * Q);
      chk("R3 cfg_err unchanged", int'(cfg_err), 0);
      brp_in = 6'd3; seg1_in = 4'd5; seg2_in = 3'd2; sjw_in = 2'd2;
   endtask

   task automatic t_hard_sync();
      int t, c, s, t2;
      wait_tx(t);
      bus_idle = 1'b1;
      c = t + 7;
      goto_cyc(c);
      rx_in = 1'b0;
      wait_sample(s);
      chk("R6 hard sync to sample", s - c, 2 + L1 * Q);
      chk("R6 sampled dominant", int'(sample_bit), 0);
      bus_idle = 1'b0;
      rx_in = 1'b1;
      wait_tx(t2);
      chk("R6 tx after hard sync", t2 - s, L2 * Q);
   endtask

   task automatic t_late(input int j, input int ext, input string req);
      int t, s, t2;
      wait_tx(t);
      goto_cyc(t + Q + j * Q + 1);
      rx_in = 1'b0;
      wait_sample(s);
      chk(req, s - t, (1 + L1 + ext) * Q);
      chk("R7 sampled dominant", int'(sample_bit), 0);
      rx_in = 1'b1;
      wait_tx(t2);
      chk("R10 rise in seg2 ignored", t2 - s, L2 * Q);
   endtask

   task automatic t_early_and_rise();
      int s, t;
      // seg2 quantum 1: error 2, jump 3 -> shortened by 2
      wait_sample(s);
      goto_cyc(s + Q + 1);
      rx_in = 1'b0;
      wait_tx(t);
      chk("R8 early edge j=1", t - s, 1 * Q + Q);
      rx_in = 1'b1;
      // seg2 quantum 0: error 3 -> ends at end of quantum 0
      wait_sample(s);
      goto_cyc(s + 1);
      rx_in = 1'b0;
      wait_tx(t);
      chk("R8 early edge j=0", t - s, Q);
      // line stays low; rise in seg1 quantum 1 must not lengthen seg1
      goto_cyc(t + 2 * Q + 1);
      rx_in = 1'b1;
      wait_sample(s);
      chk("R10 rise in seg1 ignored", s - t, (1 + L1) * Q);
      chk("R10 sampled recessive", int'(sample_bit), 1);
   endtask

   task automatic t_one_resync();
      int t, s;
      wait_tx(t);
      goto_cyc(t + Q + 1);
      rx_in = 1'b0;
      goto_cyc(t + 2 * Q + 1);
      rx_in = 1'b1;
      goto_cyc(t + 4 * Q + 1);
      rx_in = 1'b0;
      wait_sample(s);
      chk("R9 second edge ignored", s - t, (1 + L1 + 1) * Q);
      rx_in = 1'b1;
      wait_tx(t);
      wait_tx(s);
      chk("R9 next bit nominal", s - t, NBT * Q);
   endtask

   initial begin
      t_reset();
      t_cfg_err();
      t_init_release();
      t_period();
      t_ignore_writes();
      t_hard_sync();
      t_late(1, 2, "R7 late edge j=1");
      t_late(4, 3, "R7 late edge capped by jump");
      t_early_and_rise();
      t_one_resync();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: got %0d expected %0d cycles", cyc, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule